// File: doc/BRIEF.md
# Int8 Batch-Norm Scale-Shift Unit

This unit applies a quantized batch normalization to a stream of signed 8-bit feature values, placed ahead of a residual addition. Each sample arrives with a channel index. That index selects a per-channel scale and a per-channel bias, both signed 8-bit fixed-point numbers. Each parameter has its own count of fractional bits, from 0 to 15. The feature is multiplied by the scale. The bias is aligned to the product's binary point and added. The result is then scaled back to an integer, rounded and saturated to the symmetric range -127 to +127. All intermediate arithmetic is held in a 16-bit signed representation, and any intermediate that would leave it saturates instead of wrapping.

The per-channel parameters sit in a small register file. A single write port fills it, one channel per cycle. The datapath has two register stages: the multiply and the bias alignment in the first, then the add, rounding and clamp in the second. It accepts one sample every cycle, and each result appears two clock edges after its sample.

Top module: `bn_int8_affine`

## Requirements
- R1: After reset `outValid` is 0, `outData` is 0 and every channel's scale, bias and both fractional counts are 0, so a sample on a channel that has never been written produces 0.
- R2: When `cfgWe` is 1 at a rising edge, the scale, bias, scale fractional count and bias fractional count for channel `cfgCh` are replaced; no other channel changes.
- R3: A sample presented with `inValid` = 1 at rising edge k gives `outValid` = 1 after edge k+2 with its result; when `inValid` = 0 at edge k, `outValid` is 0 after edge k+2. Back-to-back samples give back-to-back results.
- R4: The product is the signed 16-bit value x*scale and carries `scaleFrac` fractional bits (the feature is an integer).
- R5: With sf = scale fractional count and bf = bias fractional count, the bias is shifted left by sf-bf and saturated to 16 bits when sf >= bf, and otherwise shifted right arithmetically (rounding toward minus infinity) by bf-sf.
- R6: The sum of product and aligned bias is saturated to [-32768, 32767].
- R7: The saturated sum is divided by 2^sf with rounding of exact halves away from zero (no rounding when sf = 0).
- R8: The rounded value is clamped to [-127, +127]; `outData` is never -128 while `outValid` is 1.
- R9: While `outValid` is 0, `outData` holds the last result.
- R10: A sample and a parameter write to the same channel at the same edge: the sample uses the parameters stored before that write; the new values take effect from the next edge.
- R11: Each sample uses the parameters of its own channel, so that interleaved channels in a stream do not mix.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Parameter write strobe |
| cfgCh | input | CH_W | Channel being written |
| cfgScale | input | DATA_W | Signed scale value |
| cfgBias | input | DATA_W | Signed bias value |
| cfgScaleFrac | input | FRAC_W | Fractional bit count of the scale |
| cfgBiasFrac | input | FRAC_W | Fractional bit count of the bias |
| inValid | input | 1 | Input sample valid |
| inCh | input | CH_W | Channel of the input sample |
| inData | input | DATA_W | Signed input feature |
| outValid | output | 1 | Result valid |
| outData | output | DATA_W | Signed result in [-127, +127] |

## Verification
A parameter write and a sample that reads the same channel can fall in the same cycle. The bench drives a sample and a write to that channel at one edge, and then a second sample to that channel at the next edge. It expects the first result to come from the old parameters and the second from the new ones. The random stream also mixes writes with samples, and its reference model applies each write only after it has computed that cycle's expected result.

// File: rtl/bn_affine_pkg.sv
package bn_affine_pkg;
  // Load strobes handed from the control to the datapath, one per stage.
  typedef struct packed {
    logic s1Load;
    logic s2Load;
  } stageCtrl_t;
endpackage

// File: rtl/bn_affine_params.sv
module bn_affine_params #(
  parameter int NUM_CH = 16,
  parameter int CH_W   = 4,
  parameter int DATA_W = 8,
  parameter int FRAC_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [CH_W-1:0]   wrCh,
  input  logic [DATA_W-1:0] wrScale,
  input  logic [DATA_W-1:0] wrBias,
  input  logic [FRAC_W-1:0] wrScaleFrac,
  input  logic [FRAC_W-1:0] wrBiasFrac,
  input  logic [CH_W-1:0]   rdCh,
  output logic [DATA_W-1:0] rdScale,
  output logic [DATA_W-1:0] rdBias,
  output logic [FRAC_W-1:0] rdScaleFrac,
  output logic [FRAC_W-1:0] rdBiasFrac
);
  logic [DATA_W-1:0] scaleMem [NUM_CH];
  logic [DATA_W-1:0] biasMem  [NUM_CH];
  logic [FRAC_W-1:0] sfMem    [NUM_CH];
  logic [FRAC_W-1:0] bfMem    [NUM_CH];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_entry
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        scaleMem[c] <= '0;
        biasMem[c]  <= '0;
        sfMem[c]    <= '0;
        bfMem[c]    <= '0;
      end else if (wrEn && (wrCh == CH_W'(c))) begin
        scaleMem[c] <= wrScale;
        biasMem[c]  <= wrBias;
        sfMem[c]    <= wrScaleFrac;
        bfMem[c]    <= wrBiasFrac;
      end
    end
  end

  // Combinational read: a write at the same edge is seen only afterwards.
  always_comb begin
    rdScale     = scaleMem[rdCh];
    rdBias      = biasMem[rdCh];
    rdScaleFrac = sfMem[rdCh];
    rdBiasFrac  = bfMem[rdCh];
  end
endmodule

// File: rtl/bn_affine_ctrl.sv
module bn_affine_ctrl
  import bn_affine_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  output stageCtrl_t ctrl,
  output logic       outValid
);
  logic stage1Valid;
  logic stage2Valid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1Valid <= 1'b0;
      stage2Valid <= 1'b0;
    end else begin
      stage1Valid <= inValid;
      stage2Valid <= stage1Valid;
    end
  end

  always_comb begin
    ctrl.s1Load = inValid;
    ctrl.s2Load = stage1Valid;
    outValid    = stage2Valid;
  end
endmodule

// File: rtl/bn_affine_datapath.sv
module bn_affine_datapath
  import bn_affine_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int FRAC_W = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  stageCtrl_t               ctrl,
  input  logic signed [DATA_W-1:0] inData,
  input  logic signed [DATA_W-1:0] scale,
  input  logic signed [DATA_W-1:0] bias,
  input  logic        [FRAC_W-1:0] scaleFrac,
  input  logic        [FRAC_W-1:0] biasFrac,
  output logic signed [DATA_W-1:0] outData
);
  localparam int ACC_W  = 2 * DATA_W;
  localparam int WIDE_W = DATA_W + (1 << FRAC_W);
  localparam int MAG_W  = ACC_W + 2;
  localparam logic signed [ACC_W-1:0]  ACC_MAX  = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0]  ACC_MIN  = {1'b1, {(ACC_W-1){1'b0}}};
  localparam logic signed [WIDE_W-1:0] WIDE_MAX = {{(WIDE_W-ACC_W){1'b0}}, ACC_MAX};
  localparam logic signed [WIDE_W-1:0] WIDE_MIN = {{(WIDE_W-ACC_W){1'b1}}, ACC_MIN};
  localparam logic        [MAG_W-1:0]  MAG_LIM  = MAG_W'((1 << (DATA_W-1)) - 1);

  // ---------------- stage 1: multiply and align the bias ----------------
  logic signed [ACC_W-1:0]  prodNext;
  logic signed [WIDE_W-1:0] biasWide;
  logic signed [WIDE_W-1:0] biasShl;
  logic signed [ACC_W-1:0]  biasAcc;
  logic signed [ACC_W-1:0]  biasAlign;
  logic        [FRAC_W-1:0] shiftAmt;

  always_comb begin
    prodNext = ACC_W'(inData) * ACC_W'(scale);
    biasWide = {{(WIDE_W-DATA_W){bias[DATA_W-1]}}, bias};
    biasAcc  = {{(ACC_W-DATA_W){bias[DATA_W-1]}}, bias};
    biasShl  = '0;
    if (scaleFrac >= biasFrac) begin
      shiftAmt = scaleFrac - biasFrac;
      biasShl  = biasWide <<< shiftAmt;
      if (biasShl > WIDE_MAX)      biasAlign = ACC_MAX;
      else if (biasShl < WIDE_MIN) biasAlign = ACC_MIN;
      else                         biasAlign = biasShl[ACC_W-1:0];
    end else begin
      shiftAmt  = biasFrac - scaleFrac;
      biasAlign = biasAcc >>> shiftAmt;
    end
  end

  logic signed [ACC_W-1:0]  prodQ;
  logic signed [ACC_W-1:0]  biasQ;
  logic        [FRAC_W-1:0] fracQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prodQ <= '0;
      biasQ <= '0;
      fracQ <= '0;
    end else if (ctrl.s1Load) begin
      prodQ <= prodNext;
      biasQ <= biasAlign;
      fracQ <= scaleFrac;
    end
  end

  // -------------- stage 2: add, round, clamp symmetrically --------------
  logic signed [ACC_W:0]   sumWide;
  logic signed [ACC_W-1:0] sumSat;
  logic signed [MAG_W-1:0] sumExt;
  logic        [MAG_W-1:0] magAbs;
  logic        [MAG_W-1:0] halfLsb;
  logic        [MAG_W-1:0] magRnd;
  logic        [DATA_W-1:0] magLim;
  logic                    isNeg;
  logic signed [DATA_W-1:0] resultNext;

  always_comb begin
    sumWide = {prodQ[ACC_W-1], prodQ} + {biasQ[ACC_W-1], biasQ};
    if (sumWide > (ACC_W+1)'(ACC_MAX))      sumSat = ACC_MAX;
    else if (sumWide < (ACC_W+1)'(ACC_MIN)) sumSat = ACC_MIN;
    else                                    sumSat = sumWide[ACC_W-1:0];

    isNeg  = sumSat[ACC_W-1];
    sumExt = {{2{sumSat[ACC_W-1]}}, sumSat};
    magAbs = isNeg ? MAG_W'(-sumExt) : MAG_W'(sumExt);

    if (fracQ == '0) halfLsb = '0;
    else             halfLsb = MAG_W'(1) << (fracQ - FRAC_W'(1));
    magRnd = (magAbs + halfLsb) >> fracQ;

    if (magRnd > MAG_LIM) magLim = MAG_LIM[DATA_W-1:0];
    else                  magLim = magRnd[DATA_W-1:0];

    resultNext = isNeg ? -$signed(magLim) : $signed(magLim);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             outData <= '0;
    else if (ctrl.s2Load)  outData <= resultNext;
  end
endmodule

// File: rtl/bn_int8_affine.sv
module bn_int8_affine
  import bn_affine_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int DATA_W = 8,
  parameter int FRAC_W = 4,
  parameter int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [CH_W-1:0]   cfgCh,
  input  logic [DATA_W-1:0] cfgScale,
  input  logic [DATA_W-1:0] cfgBias,
  input  logic [FRAC_W-1:0] cfgScaleFrac,
  input  logic [FRAC_W-1:0] cfgBiasFrac,
  input  logic              inValid,
  input  logic [CH_W-1:0]   inCh,
  input  logic [DATA_W-1:0] inData,
  output logic              outValid,
  output logic [DATA_W-1:0] outData
);
  stageCtrl_t        ctrl;
  logic [DATA_W-1:0] selScale;
  logic [DATA_W-1:0] selBias;
  logic [FRAC_W-1:0] selScaleFrac;
  logic [FRAC_W-1:0] selBiasFrac;
  logic signed [DATA_W-1:0] dpOut;

  bn_affine_params #(
    .NUM_CH(NUM_CH), .CH_W(CH_W), .DATA_W(DATA_W), .FRAC_W(FRAC_W)
  ) u_params (
    .clk(clk), .rstN(rstN),
    .wrEn(cfgWe), .wrCh(cfgCh),
    .wrScale(cfgScale), .wrBias(cfgBias),
    .wrScaleFrac(cfgScaleFrac), .wrBiasFrac(cfgBiasFrac),
    .rdCh(inCh),
    .rdScale(selScale), .rdBias(selBias),
    .rdScaleFrac(selScaleFrac), .rdBiasFrac(selBiasFrac)
  );

  bn_affine_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .ctrl(ctrl), .outValid(outValid)
  );

  bn_affine_datapath #(
    .DATA_W(DATA_W), .FRAC_W(FRAC_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .inData($signed(inData)), .scale($signed(selScale)), .bias($signed(selBias)),
    .scaleFrac(selScaleFrac), .biasFrac(selBiasFrac),
    .outData(dpOut)
  );

  assign outData = dpOut;
endmodule

// File: rtl/bn_affine_checker.sv
module bn_affine_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              outValid,
  input logic [DATA_W-1:0] outData
);
  localparam logic [DATA_W-1:0] NEG_EDGE = {1'b1, {(DATA_W-1){1'b0}}};

  p_latency_r3: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> ##1 outValid);

  p_bubble_r3: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ##1 !outValid);

  p_no_min_code_r8: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outData != NEG_EDGE));

  p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> $stable(outData));
endmodule

bind bn_int8_affine bn_affine_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid),
  .outValid(outValid), .outData(outData)
);

// File: tb/bn_int8_affine_tb.sv
module bn_int8_affine_tb;
  localparam int NUM_CH = 16;
  localparam int DATA_W = 8;
  localparam int FRAC_W = 4;
  localparam int CH_W   = 4;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              cfgWe = 1'b0;
  logic [CH_W-1:0]   cfgCh = '0;
  logic [DATA_W-1:0] cfgScale = '0;
  logic [DATA_W-1:0] cfgBias = '0;
  logic [FRAC_W-1:0] cfgScaleFrac = '0;
  logic [FRAC_W-1:0] cfgBiasFrac = '0;
  logic              inValid = 1'b0;
  logic [CH_W-1:0]   inCh = '0;
  logic [DATA_W-1:0] inData = '0;
  logic              outValid;
  logic [DATA_W-1:0] outData;

  always #2 clk = ~clk;

  bn_int8_affine #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgCh(cfgCh),
    .cfgScale(cfgScale), .cfgBias(cfgBias),
    .cfgScaleFrac(cfgScaleFrac), .cfgBiasFrac(cfgBiasFrac),
    .inValid(inValid), .inCh(inCh), .inData(inData),
    .outValid(outValid), .outData(outData)
  );

  int vectors = 0;
  int misses  = 0;
  bit done    = 1'b0;

  // shadow parameters and a two-deep expectation pipe
  int shScale [NUM_CH];
  int shBias  [NUM_CH];
  int shSf    [NUM_CH];
  int shBf    [NUM_CH];
  bit    pipeV [2];
  int    pipeD [2];
  string pipeT [2];
  int lastOut = 0;

  bit wrPend = 1'b0;
  int wrCh, wrS, wrB, wrSf, wrBf;

  function automatic int clampInt(int v, int lo, int hi);
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  function automatic int refModel(int x, int s, int b, int sf, int bf);
    int p, ba, sum, m, q;
    p = x * s;
    if (sf >= bf) ba = clampInt(b * (1 << (sf - bf)), -32768, 32767);
    else          ba = b >>> (bf - sf);
    sum = clampInt(p + ba, -32768, 32767);
    if (sf == 0) q = sum;
    else begin
      m = (sum < 0) ? -sum : sum;
      m = (m + (1 << (sf - 1))) >> sf;
      q = (sum < 0) ? -m : m;
    end
    return clampInt(q, -127, 127);
  endfunction

  task automatic check(string tag, int got, int exp);
    vectors++;
    if (got != exp) begin
      misses++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic wr(int ch, int s, int b, int sf, int bf);
    wrPend = 1'b1; wrCh = ch; wrS = s; wrB = b; wrSf = sf; wrBf = bf;
  endtask

  // One clock cycle, entered and left at a falling edge.
  task automatic cycle(bit v, int ch, int x, string tag);
    int got;
    got = $signed(outData);
    if (pipeV[1]) begin
      check({pipeT[1], " R3 valid"}, int'(outValid), 1);
      check(pipeT[1], got, pipeD[1]);
    end else begin
      check("R3 idle valid", int'(outValid), 0);
      check("R9 hold", got, lastOut);
    end
    if (outValid) lastOut = got;
    pipeV[1] = pipeV[0]; pipeD[1] = pipeD[0]; pipeT[1] = pipeT[0];
    pipeV[0] = v;
    pipeD[0] = v ? refModel(x, shScale[ch], shBias[ch], shSf[ch], shBf[ch]) : 0;
    pipeT[0] = tag;
    inValid = v; inCh = CH_W'(ch); inData = DATA_W'(x);
    cfgWe = wrPend;
    if (wrPend) begin
      cfgCh = CH_W'(wrCh); cfgScale = DATA_W'(wrS); cfgBias = DATA_W'(wrB);
      cfgScaleFrac = FRAC_W'(wrSf); cfgBiasFrac = FRAC_W'(wrBf);
      shScale[wrCh] = wrS; shBias[wrCh] = wrB; shSf[wrCh] = wrSf; shBf[wrCh] = wrBf;
      wrPend = 1'b0;
    end
    @(negedge clk);
  endtask

  task automatic flush();
    cycle(0, 0, 0, "idle");
    cycle(0, 0, 0, "idle");
  endtask

  task automatic testReset();
    for (int c = 0; c < NUM_CH; c++) begin
      shScale[c] = 0; shBias[c] = 0; shSf[c] = 0; shBf[c] = 0;
    end
    pipeV[0] = 0; pipeV[1] = 0;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset valid", int'(outValid), 0);
    check("R1 reset data", $signed(outData), 0);
    rstN = 1'b1;
    @(negedge clk);
    cycle(1, 5, 100, "R1 unwritten channel");
    cycle(1, 15, -77, "R1 unwritten channel");
    flush();
  endtask

  task automatic testWriteIsolation();
    wr(2, 3, 0, 0, 0); cycle(0, 0, 0, "cfg");
    cycle(1, 3, 10, "R2 neighbour untouched");
    cycle(1, 2, 10, "R2 written channel");
    cycle(1, 1, 10, "R2 neighbour untouched");
    flush();
  endtask

  task automatic testChannels();
    wr(0, 64, 0, 6, 0);  cycle(0, 0, 0, "cfg");
    wr(1, -32, 0, 4, 0); cycle(0, 0, 0, "cfg");
    wr(7, 5, -7, 0, 0);  cycle(0, 0, 0, "cfg");
    cycle(1, 0, 45,  "R11 R4 ch0 unity");
    cycle(1, 1, 45,  "R11 R4 ch1 times -2");
    cycle(1, 7, 20,  "R11 R4 ch7 5x-7");
    cycle(1, 0, -90, "R11 ch0");
    cycle(1, 1, -30, "R11 ch1");
    cycle(1, 7, -4,  "R11 ch7");
    flush();
  endtask

  task automatic testBiasAlign();
    wr(4, 16, 3, 4, 0);  cycle(0, 0, 0, "cfg");
    cycle(1, 4, 2,  "R5 bias shifted left");
    cycle(1, 4, -9, "R5 bias shifted left");
    wr(5, 2, -5, 1, 3);  cycle(0, 0, 0, "cfg");
    cycle(1, 5, 3,  "R5 bias shifted right floor");
    cycle(1, 5, 0,  "R5 bias shifted right floor");
    wr(6, 1, 100, 0, 7); cycle(0, 0, 0, "cfg");
    cycle(1, 6, 10, "R5 bias right shift by 7");
    wr(6, 1, 127, 15, 0); cycle(0, 0, 0, "cfg");
    cycle(1, 6, 0,  "R5 left shift saturates");
    flush();
  endtask

  task automatic testAddSat();
    wr(8, 127, 127, 15, 0);   cycle(0, 0, 0, "cfg");
    cycle(1, 8, 127,  "R6 positive sum saturates");
    wr(8, 127, -128, 15, 0);  cycle(0, 0, 0, "cfg");
    cycle(1, 8, -127, "R6 negative sum saturates");
    flush();
    check("R6 positive literal", refModel(127, 127, 127, 15, 0), 1);
  endtask

  task automatic testRounding();
    wr(10, 1, 0, 1, 0); cycle(0, 0, 0, "cfg");
    cycle(1, 10, 3,  "R7 +1.5 rounds to 2");
    cycle(1, 10, -3, "R7 -1.5 rounds to -2");
    cycle(1, 10, 1,  "R7 +0.5 rounds to 1");
    cycle(1, 10, -1, "R7 -0.5 rounds to -1");
    wr(10, 1, 0, 2, 0); cycle(0, 0, 0, "cfg");
    cycle(1, 10, 5,  "R7 1.25 rounds to 1");
    cycle(1, 10, 6,  "R7 1.5 rounds to 2");
    cycle(1, 10, -6, "R7 -1.5 rounds to -2");
    cycle(1, 10, -5, "R7 -1.25 rounds to -1");
    flush();
  endtask

  task automatic testClamp();
    wr(11, 127, 127, 0, 0); cycle(0, 0, 0, "cfg");
    cycle(1, 11, 127,  "R8 clamp at +127");
    cycle(1, 11, -128, "R8 clamp at -127");
    wr(12, -128, 0, 0, 0);  cycle(0, 0, 0, "cfg");
    cycle(1, 12, -128, "R8 -128 times -128 clamps +127");
    wr(12, 1, 0, 0, 0);     cycle(0, 0, 0, "cfg");
    cycle(1, 12, -128, "R8 -128 passthrough becomes -127");
    cycle(1, 12, 127,  "R8 127 passthrough");
    flush();
  endtask

  task automatic testSameCycle();
    wr(9, 2, 0, 0, 0); cycle(0, 0, 0, "cfg");
    wr(9, 5, 0, 0, 0);
    cycle(1, 9, 10, "R10 old parameters in write cycle");
    cycle(1, 9, 10, "R10 new parameters next cycle");
    flush();
  endtask

  task automatic testStream();
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 3) == 0)
        wr($urandom_range(0, NUM_CH-1), int'($urandom_range(0, 255)) - 128,
           int'($urandom_range(0, 255)) - 128, $urandom_range(0, 15), $urandom_range(0, 15));
      if ($urandom_range(0, 4) == 0) cycle(0, 0, 0, "idle");
      else cycle(1, $urandom_range(0, NUM_CH-1), int'($urandom_range(0, 255)) - 128,
                 "R3 R10 R11 random stream");
    end
    flush();
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  endtask

  initial begin
    @(negedge clk);
    testReset();
    testWriteIsolation();
    testChannels();
    testBiasAlign();
    testAddSat();
    testRounding();
    testClamp();
    testSameCycle();
    testStream();
    finishRun();
  end

  initial begin
    #(4 * 150000);
    vectors++;
    misses++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end
endmodule